// File: doc/BRIEF.md
# Interprocessor and Timer Interrupt Controller

This block keeps, for up to four processors, one pending interprocessor-interrupt (IPI) bit and one pending timer-interrupt bit. Each pending bit drives its own interrupt line. Software reaches the block through a 64-bit register port with four selectable registers:

- a combined control register;
- a pending-IPI register, where a write clears the selected IPIs;
- a pending-timer register, where a write clears the selected timer interrupts;
- an IPI post register.

Every operation names its targets with a 4-bit processor mask. Bit i of a mask selects processor i.

A periodic tick input raises the timer interrupt of every present processor. One control-register write can post IPIs, clear IPIs and clear timer interrupts at once. It can also carry a memory-error acknowledge bit, which the block accepts and does not act on.

Misuse is reported on two registered pulses. A write that does nothing, or that carries an empty mask, is an error. A post to a processor whose IPI is already pending is a redundant operation and raises a warning. So is a clear of an IPI that is not pending. The parameter `NUM_CPU` (1 to 4) sets how many processors are present.

Top module: `ipi_tmr_ctrl`

## Requirements
- R1: After reset, all pending bits, both interrupt line vectors, `wr_err` and `wr_warn` are 0.
- R2: A write with `reg_sel`=0 (control) applies three masks in the same cycle: `reg_wdata[15:12]` posts IPIs, `reg_wdata[11:8]` clears IPIs and `reg_wdata[7:4]` clears timer interrupts. If a write posts and clears the same IPI, the post is applied first and the clear second, so the bit ends cleared with no warning.
- R3: When `reg_wdata[28]` is set in a control write, that bit is accepted with no effect on state and raises no error.
- R4: A control write whose bits 15:4 are all 0 and whose bit 28 is 0 changes no state and pulses `wr_err` in the next cycle.
- R5: An IPI post to a present processor whose IPI is already pending leaves that bit unchanged and pulses `wr_warn` in the next cycle.
- R6: An IPI clear to a present processor with no pending IPI leaves that bit unchanged and pulses `wr_warn` in the next cycle. This includes the effect of any post in the same write.
- R7: A cycle with `tick` high sets the timer bit of every present processor. If a timer clear arrives in the same cycle, the tick wins.
- R8: Writes select registers by `reg_sel`, using the mask in `reg_wdata[3:0]`: `reg_sel`=1 clears IPIs, `reg_sel`=2 clears timer interrupts and `reg_sel`=3 posts IPIs.
- R9: A write with `reg_sel` of 1, 2 or 3 and `reg_wdata[3:0]`=0 changes no state and pulses `wr_err` in the next cycle.
- R10: `reg_rdata` depends on `reg_sel`, and every unlisted bit is 0:
  - `reg_sel`=0: pending IPIs in 11:8, pending timer bits in 7:4 and `reg_cpu_id` in 1:0.
  - `reg_sel`=1: pending IPIs in 3:0.
  - `reg_sel`=2: pending timer bits in 3:0.
  - `reg_sel`=3: all zero.
- R11: Mask bits for processors at index `NUM_CPU` or above are ignored. They cause no change and no warning, and their interrupt lines stay 0.
- R12: The interrupt lines are the registered pending bits. They change only in the cycle after a write or tick, and `wr_err`/`wr_warn` are one-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 pending IPI, 2 pending timer, 3 IPI post |
| reg_wdata | input | 64 | Write data |
| reg_cpu_id | input | 2 | Identifier of the processor making the access |
| reg_rdata | output | 64 | Read data for the selected register |
| tick | input | 1 | Periodic timer tick |
| ipi_irq | output | 4 | Per-processor IPI interrupt lines |
| tmr_irq | output | 4 | Per-processor timer interrupt lines |
| wr_err | output | 1 | Pulse: unsupported write or empty mask |
| wr_warn | output | 1 | Pulse: redundant IPI post or clear |

## Verification
The assertions assume that `reg_wr`, `reg_sel` and `reg_wdata` are valid at every rising edge that follows reset. They also assume that a write and a tick may share a cycle, and that `reg_wdata` may hold mask bits for absent processors. The bench drives every input on the falling edge and keeps each write strobe to a single cycle. It deliberately sends absent-processor mask bits and a tick together with a timer clear, so both of those assumptions are exercised.

// File: rtl/ipi_tmr_pkg.sv
package ipi_tmr_pkg;
  localparam int MASK_W = 4;
  localparam int DATA_W = 64;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_IPI  = 2'd1,
    SEL_TMR  = 2'd2,
    SEL_POST = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [MASK_W-1:0] ipi_set;
    logic [MASK_W-1:0] ipi_clr;
    logic [MASK_W-1:0] tmr_clr;
    logic              err;
  } op_t;

  function automatic logic [MASK_W-1:0] present_mask(input int n);
    logic [MASK_W-1:0] m;
    for (int i = 0; i < MASK_W; i++) m[i] = (i < n);
    return m;
  endfunction

  // post first, then clear
  function automatic logic ipi_next(input logic cur, input logic set, input logic clr);
    return (cur | set) & ~clr;
  endfunction

  // tick wins over clear
  function automatic logic tmr_next(input logic cur, input logic clr, input logic tk);
    return (cur & ~clr) | tk;
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_word(input logic [MASK_W-1:0] ipi,
                                                 input logic [MASK_W-1:0] tmr,
                                                 input logic [1:0] id);
    logic [DATA_W-1:0] w;
    w = '0;
    w[11:8] = ipi;
    w[7:4]  = tmr;
    w[1:0]  = id;
    return w;
  endfunction
endpackage

// File: rtl/ipi_tmr_decode.sv
module ipi_tmr_decode
  import ipi_tmr_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic              wr,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  output op_t               op
);
  localparam logic [MASK_W-1:0] PRES = present_mask(NUM_CPU);

  logic unused_hi;
  assign unused_hi = ^{wdata[63:29], wdata[27:16]};

  op_t raw;
  always_comb begin
    raw = '0;
    unique case (reg_sel_e'(sel))
      SEL_CTRL: begin
        raw.ipi_set = wdata[15:12];
        raw.ipi_clr = wdata[11:8];
        raw.tmr_clr = wdata[7:4];
        raw.err     = ~(|wdata[15:4]) & ~wdata[28];
      end
      SEL_IPI: begin
        raw.ipi_clr = wdata[3:0];
        raw.err     = ~(|wdata[3:0]);
      end
      SEL_TMR: begin
        raw.tmr_clr = wdata[3:0];
        raw.err     = ~(|wdata[3:0]);
      end
      default: begin
        raw.ipi_set = wdata[3:0];
        raw.err     = ~(|wdata[3:0]);
      end
    endcase
  end

  always_comb begin
    op = '0;
    if (wr) begin
      op.ipi_set = raw.ipi_set & PRES;
      op.ipi_clr = raw.ipi_clr & PRES;
      op.tmr_clr = raw.tmr_clr & PRES;
      op.err     = raw.err;
    end
  end
endmodule

// File: rtl/ipi_tmr_pending.sv
module ipi_tmr_pending
  import ipi_tmr_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_t               op,
  input  logic              tick,
  output logic [MASK_W-1:0] ipi_q,
  output logic [MASK_W-1:0] tmr_q,
  output logic [MASK_W-1:0] warn_bits
);
  for (genvar i = 0; i < MASK_W; i++) begin : g_cpu
    if (i < NUM_CPU) begin : g_live
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ipi_q[i] <= 1'b0;
          tmr_q[i] <= 1'b0;
        end else begin
          ipi_q[i] <= ipi_next(ipi_q[i], op.ipi_set[i], op.ipi_clr[i]);
          tmr_q[i] <= tmr_next(tmr_q[i], op.tmr_clr[i], tick);
        end
      end
      assign warn_bits[i] = (op.ipi_set[i] & ipi_q[i]) |
                            (op.ipi_clr[i] & ~(ipi_q[i] | op.ipi_set[i]));
    end else begin : g_absent
      assign ipi_q[i]     = 1'b0;
      assign tmr_q[i]     = 1'b0;
      assign warn_bits[i] = 1'b0;
    end
  end
endmodule

// File: rtl/ipi_tmr_ctrl.sv
module ipi_tmr_ctrl
  import ipi_tmr_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [1:0]        reg_cpu_id,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tick,
  output logic [MASK_W-1:0] ipi_irq,
  output logic [MASK_W-1:0] tmr_irq,
  output logic              wr_err,
  output logic              wr_warn
);
  op_t               op;
  logic [MASK_W-1:0] warn_bits;

  ipi_tmr_decode #(.NUM_CPU(NUM_CPU)) u_dec (
    .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata), .op(op)
  );

  ipi_tmr_pending #(.NUM_CPU(NUM_CPU)) u_pend (
    .clk(clk), .rst_n(rst_n), .op(op), .tick(tick),
    .ipi_q(ipi_irq), .tmr_q(tmr_irq), .warn_bits(warn_bits)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_err  <= 1'b0;
      wr_warn <= 1'b0;
    end else begin
      wr_err  <= op.err;
      wr_warn <= |warn_bits;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel_e'(reg_sel))
      SEL_CTRL: reg_rdata = ctrl_word(ipi_irq, tmr_irq, reg_cpu_id);
      SEL_IPI:  reg_rdata[3:0] = ipi_irq;
      SEL_TMR:  reg_rdata[3:0] = tmr_irq;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ipi_tmr_ctrl_chk.sv
module ipi_tmr_ctrl_chk
  import ipi_tmr_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_sel,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              tick,
  input logic [MASK_W-1:0] ipi_irq,
  input logic [MASK_W-1:0] tmr_irq,
  input logic              wr_err,
  input logic              wr_warn
);
  localparam logic [MASK_W-1:0] PRES = present_mask(NUM_CPU);

  p_tick_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ((tmr_irq & PRES) == PRES));

  p_absent_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((ipi_irq | tmr_irq) & ~PRES) == '0);

  p_unsupported_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd0 && reg_wdata[15:4] == '0 && !reg_wdata[28])
      |=> (wr_err && $stable(ipi_irq)));

  p_empty_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel != 2'd0 && reg_wdata[3:0] == '0) |=> (wr_err && $stable(ipi_irq)));

  p_post_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd3)
      |=> ((ipi_irq & $past(reg_wdata[3:0]) & PRES) == ($past(reg_wdata[3:0]) & PRES)));

  p_clear_ipi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd1) |=> ((ipi_irq & $past(reg_wdata[3:0])) == '0));

  p_redundant_post_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd3 && reg_wdata[3:0] != '0 &&
     (reg_wdata[3:0] & PRES & ~ipi_irq) == '0) |=> $stable(ipi_irq));

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> ($stable(ipi_irq) && !wr_err && !wr_warn));
endmodule

bind ipi_tmr_ctrl ipi_tmr_ctrl_chk #(.NUM_CPU(NUM_CPU)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .tick(tick), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq),
  .wr_err(wr_err), .wr_warn(wr_warn)
);

// File: tb/ipi_tmr_ctrl_tb.sv
module ipi_tmr_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [63:0] reg_wdata = '0;
  logic [1:0]  reg_cpu_id = 2'd0;
  logic [63:0] reg_rdata;
  logic        tick = 1'b0;
  logic [3:0]  ipi_irq, tmr_irq;
  logic        wr_err, wr_warn;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    logic [3:0] ipi;
    logic [3:0] tmr;
    logic       err;
    logic       warn;
    string      tag;
  } exp_t;
  exp_t sb[$];

  logic [3:0] m_ipi = '0;
  logic [3:0] m_tmr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_tmr_ctrl #(.NUM_CPU(NCPU)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_cpu_id(reg_cpu_id), .reg_rdata(reg_rdata),
    .tick(tick), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq),
    .wr_err(wr_err), .wr_warn(wr_warn)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compares registered outputs one half-cycle after each edge
  always @(negedge clk) begin
    if (sb.size() != 0) begin
      exp_t e;
      e = sb.pop_front();
      chk({e.tag, " ipi"},  {60'd0, ipi_irq}, {60'd0, e.ipi});
      chk({e.tag, " tmr"},  {60'd0, tmr_irq}, {60'd0, e.tmr});
      chk({e.tag, " err"},  {63'd0, wr_err},  {63'd0, e.err});
      chk({e.tag, " warn"}, {63'd0, wr_warn}, {63'd0, e.warn});
    end
  end

  // driver: applies one cycle of stimulus and pushes the model's outcome
  task automatic drive(input logic wr, input logic [1:0] sel, input logic [63:0] d,
                       input logic tk, input string tag);
    logic [3:0] post, clr, tclr;
    logic e, w;
    @(negedge clk);
    reg_wr = wr; reg_sel = sel; reg_wdata = d; tick = tk;
    @(posedge clk);
    #1;
    reg_wr = 1'b0; tick = 1'b0;
    post = '0; clr = '0; tclr = '0; e = 1'b0; w = 1'b0;
    if (wr) begin
      case (sel)
        2'd0: begin
          post = d[15:12]; clr = d[11:8]; tclr = d[7:4];
          e = (d[15:4] == '0) && !d[28];
        end
        2'd1: begin clr = d[3:0];  e = (d[3:0] == '0); end
        2'd2: begin tclr = d[3:0]; e = (d[3:0] == '0); end
        default: begin post = d[3:0]; e = (d[3:0] == '0); end
      endcase
    end
    for (int i = 0; i < NCPU; i++) begin
      if (post[i]) begin
        if (m_ipi[i]) w = 1'b1;
        m_ipi[i] = 1'b1;
      end
      if (clr[i]) begin
        if (!m_ipi[i]) w = 1'b1;
        m_ipi[i] = 1'b0;
      end
      if (tclr[i]) m_tmr[i] = 1'b0;
      if (tk) m_tmr[i] = 1'b1;
    end
    sb.push_back('{m_ipi, m_tmr, e, w, tag});
  endtask

  task automatic read_chk(input logic [1:0] sel, input logic [1:0] id,
                          input logic [63:0] exp, input string tag);
    @(negedge clk);
    reg_sel = sel; reg_cpu_id = id;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ipi", {60'd0, ipi_irq}, 64'd0);
    chk("R1 tmr", {60'd0, tmr_irq}, 64'd0);
    chk("R1 err", {62'd0, wr_err, wr_warn}, 64'd0);
    rst_n = 1'b1;

    drive(1, 2'd0, 64'h3000, 0, "R2 post cpu0,1");
    drive(1, 2'd0, 64'h0100, 0, "R2 clear cpu0");
    drive(1, 2'd0, 64'h2000, 0, "R5 redundant post");
    drive(1, 2'd0, 64'h0400, 0, "R6 clear not pending");
    drive(1, 2'd0, 64'h4400, 0, "R2 post+clear same cpu");
    drive(1, 2'd0, 64'h1000_0000, 0, "R3 nxm ack");
    drive(1, 2'd0, 64'h0000_000F, 0, "R4 unsupported");
    drive(0, 2'd0, 64'h0, 1, "R7 tick");
    drive(0, 2'd0, 64'h0, 0, "R12 idle hold");

    read_chk(2'd0, 2'd2, 64'h272, "R10 ctrl read");
    read_chk(2'd1, 2'd0, 64'h2, "R10 ipi read");
    read_chk(2'd2, 2'd0, 64'h7, "R10 tmr read");
    read_chk(2'd3, 2'd0, 64'h0, "R10 post read");

    drive(1, 2'd0, 64'h0050, 0, "R2 timer clear");
    drive(1, 2'd2, 64'h2, 0, "R8 tmr reg clear");
    drive(1, 2'd3, 64'h5, 0, "R8 post reg");
    drive(1, 2'd1, 64'h3, 0, "R8 ipi reg clear");
    drive(1, 2'd3, 64'h0, 0, "R9 empty post");
    drive(1, 2'd1, 64'h0, 0, "R9 empty ipi clear");
    drive(1, 2'd2, 64'h0, 0, "R9 empty tmr clear");
    drive(1, 2'd3, 64'h8, 0, "R11 absent post");
    drive(1, 2'd1, 64'h8, 0, "R11 absent clear");
    drive(1, 2'd2, 64'h7, 1, "R7 tick beats clear");
    drive(1, 2'd3, 64'h4, 0, "R5 redundant post reg");
    drive(1, 2'd0, 64'hF000, 1, "R11 ctrl post with absent bit");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule